// File: doc/BRIEF.md
# Synchronizable Clock Divider with Whole-Period Delay

This block is one channel of a converter clock-distribution path. It takes the channel's input clock and produces an output clock at the input rate divided by 1, 2, 4, 6, 8, 12 or 16. Ratio 1 sends the input clock straight to the output through a single gate and skips the counter. A coarse delay can hold back the start of the output by a whole number of input periods, from 0 to 255.

Several channels share one synchronization pulse. The pulse is sampled on the rising input edge. It loads the pending ratio and delay settings, clears the divider phase and starts a fixed countdown. All channels that receive the pulse therefore produce output edges in a known, repeatable relation to one another and to the pulse. Ratio and delay settings written at any other time have no effect on the running output. A per-channel enable forces the output low at once. When the enable is set again, the output comes back only at the start of a full period.

Top module: `sdiv_channel`

## Requirements
- R1: The ratio field (3 bits) selects the division ratio as follows: 000 gives ÷1, 001 gives ÷2, 010 gives ÷4, 011 gives ÷6, 100 gives ÷8, 101 gives ÷12 and 110 gives ÷16. For every even ratio N, the output is high for N/2 input cycles and then low for N/2 input cycles.
- R2: Code 111 is loaded as ÷1. After the input edge that samples the sync pulse which loaded it, `cfg_err` is 1. `cfg_err` returns to 0 after a sync pulse that loads a valid code.
- R3: At ÷1, once the output is running, it equals the input clock: high while the input is high and low while the input is low.
- R4: Let t0 be the input edge that samples `sync_i` high and D the delay field. The output is low after edges t0+1 through t0+D+1, and its first high phase begins at edge t0+D+2.
- R5: The delay field is 8 bits wide. All 256 values are honoured, up to D=255, which gives a first high at edge t0+257.
- R6: Changes to the ratio or delay fields while `sync_i` is low leave the output waveform unchanged.
- R7: While `out_en` is low, the output is low from the first edge that samples it low.
- R8: After `out_en` returns high, the output resumes only at an edge where a new high phase begins. It never starts part-way through a period.
- R9: After reset and before the first sync pulse, `clk_out` and `cfg_err` are 0.
- R10: A sync pulse that arrives while the output is running restarts it with the timing of R4. This holds regardless of the phase the old pattern was in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Alignment pulse; loads settings and restarts the phase |
| ratio_cfg | input | 3 | Pending division ratio code |
| delay_cfg | input | 8 | Pending start delay in input periods |
| out_en | input | 1 | Output enable |
| clk_out | output | 1 | Divided, delayed and gated output clock |
| cfg_err | output | 1 | Active ratio code is the reserved value |

## Verification
Two events can land on the same input edge.

The first pair is a sync pulse and a rising edge of the old waveform. The sync edge itself still shows the old pattern; the next edge must drop the output. The bench issues a re-sync in the middle of a ÷16 and then a ÷8 pattern. Its reference model finishes the old pattern for the sync edge and only then applies the new start edge.

The second pair is an enable that returns in the same cycle as a period boundary. The expected output that the model pushes into the scoreboard must show the output rise on exactly that boundary, neither one cycle early nor one cycle late.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  localparam int RCODE_W = 3;
  localparam int RVAL_W  = 5;

  typedef logic [RCODE_W-1:0] rcode_t;
  typedef logic [RVAL_W-1:0]  rval_t;

  localparam rcode_t RCODE_BAD = 3'b111;

  typedef struct packed {
    rval_t ratio;
    logic  byp;
    logic  err;
  } shadow_t;

  function automatic rval_t ratio_of(input rcode_t code);
    case (code)
      3'd0:    return rval_t'(1);
      3'd1:    return rval_t'(2);
      3'd2:    return rval_t'(4);
      3'd3:    return rval_t'(6);
      3'd4:    return rval_t'(8);
      3'd5:    return rval_t'(12);
      3'd6:    return rval_t'(16);
      default: return rval_t'(1);
    endcase
  endfunction

endpackage

// File: rtl/sdiv_cfg_shadow.sv
module sdiv_cfg_shadow
  import sdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_i,
  input  rcode_t code_i,
  output rval_t  ratio_o,
  output logic   byp_o,
  output logic   err_o
);

  shadow_t sh_q;
  shadow_t sh_d;
  rval_t   dec_ratio;

  assign dec_ratio = ratio_of(code_i);

  always_comb begin
    sh_d = sh_q;
    if (sync_i) begin
      sh_d.ratio = dec_ratio;
      sh_d.byp   = (dec_ratio == rval_t'(1));
      sh_d.err   = (code_i == RCODE_BAD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q.ratio <= rval_t'(1);
      sh_q.byp   <= 1'b1;
      sh_q.err   <= 1'b0;
    end else if (sync_i) begin
      sh_q <= sh_d;
    end
  end

  assign ratio_o = sh_q.ratio;
  assign byp_o   = sh_q.byp;
  assign err_o   = sh_q.err;

endmodule

// File: rtl/sdiv_delay_arm.sv
module sdiv_delay_arm #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             start_o
);

  logic             arm_q, arm_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;
  logic             upd_en;

  assign cnt_zero = (cnt_q == '0);
  assign upd_en   = sync_i | arm_q;

  always_comb begin
    arm_d   = arm_q;
    cnt_d   = cnt_q;
    start_o = arm_q && cnt_zero && !sync_i;
    if (sync_i) begin
      arm_d = 1'b1;
      cnt_d = dly_i;
    end else if (arm_q) begin
      if (cnt_zero) arm_d = 1'b0;
      else          cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd_en) begin
      arm_q <= arm_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sdiv_phase_ctr.sv
module sdiv_phase_ctr
  import sdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_i,
  input  logic  start_i,
  input  rval_t ratio_i,
  input  logic  byp_i,
  output logic  bound_o,
  output logic  div_o
);

  rval_t cnt_q, cnt_d;
  logic  run_q, run_d;
  logic  div_q, div_d;
  rval_t hi_len;
  logic  at_last;
  logic  cnt_en;

  assign hi_len  = byp_i ? rval_t'(1) : (ratio_i >> 1);
  assign at_last = (cnt_q == ratio_i - rval_t'(1));
  assign cnt_en  = sync_i | start_i | run_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    div_d = run_q && (cnt_q < hi_len);
    if (sync_i) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (start_i) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = at_last ? '0 : cnt_q + rval_t'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_en) begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= div_d;
  end

  assign bound_o = run_q && (cnt_q == '0);
  assign div_o   = div_q;

endmodule

// File: rtl/sdiv_out_gate.sv
module sdiv_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic out_en,
  input  logic bound_i,
  input  logic div_i,
  input  logic byp_i,
  output logic en_o,
  output logic clk_out
);

  logic en_q, en_d;

  always_comb begin
    en_d = en_q;
    if (!out_en)      en_d = 1'b0;
    else if (bound_i) en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign en_o    = en_q;
  assign clk_out = div_i & en_q & (byp_i ? clk : 1'b1);

endmodule

// File: rtl/sdiv_channel.sv
module sdiv_channel
  import sdiv_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [2:0]       ratio_cfg,
  input  logic [DLY_W-1:0] delay_cfg,
  input  logic             out_en,
  output logic             clk_out,
  output logic             cfg_err
);

  logic  rst_meta_q, rst_sync_n;
  rval_t act_ratio_w;
  logic  byp_w;
  logic  start_w;
  logic  bound_w;
  logic  div_w;
  logic  en_w;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  sdiv_cfg_shadow u_shadow (
    .clk     (clk_in),
    .rst_n   (rst_sync_n),
    .sync_i  (sync_i),
    .code_i  (ratio_cfg),
    .ratio_o (act_ratio_w),
    .byp_o   (byp_w),
    .err_o   (cfg_err)
  );

  sdiv_delay_arm #(.DLY_W(DLY_W)) u_arm (
    .clk     (clk_in),
    .rst_n   (rst_sync_n),
    .sync_i  (sync_i),
    .dly_i   (delay_cfg),
    .start_o (start_w)
  );

  sdiv_phase_ctr u_ctr (
    .clk     (clk_in),
    .rst_n   (rst_sync_n),
    .sync_i  (sync_i),
    .start_i (start_w),
    .ratio_i (act_ratio_w),
    .byp_i   (byp_w),
    .bound_o (bound_w),
    .div_o   (div_w)
  );

  sdiv_out_gate u_gate (
    .clk     (clk_in),
    .rst_n   (rst_sync_n),
    .out_en  (out_en),
    .bound_i (bound_w),
    .div_i   (div_w),
    .byp_i   (byp_w),
    .en_o    (en_w),
    .clk_out (clk_out)
  );

endmodule

// File: rtl/sdiv_channel_chk.sv
module sdiv_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_i,
  input logic [2:0] ratio_cfg,
  input logic       out_en,
  input logic       cfg_err,
  input logic       en_q,
  input logic       div_q,
  input logic [4:0] act_ratio
);

  // R7
  disabled_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !en_q);

  // R8
  reenable_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> div_q);

  // R4
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> ##2 !div_q);

  // R2
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && ratio_cfg == 3'b111) |=> cfg_err);

  // R6
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> $stable(act_ratio));

endmodule

bind sdiv_channel sdiv_channel_chk i_chk (
  .clk       (clk_in),
  .rst_n     (rst_n),
  .sync_i    (sync_i),
  .ratio_cfg (ratio_cfg),
  .out_en    (out_en),
  .cfg_err   (cfg_err),
  .en_q      (en_w),
  .div_q     (div_w),
  .act_ratio (act_ratio_w)
);

// File: tb/test_sdiv_channel.sv
module test_sdiv_channel;

  logic       clk_in = 1'b0;
  logic       rst_n;
  logic       sync_i;
  logic [2:0] ratio_cfg;
  logic [7:0] delay_cfg;
  logic       out_en;
  logic       clk_out;
  logic       cfg_err;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int    cyc;
    logic  hi;
    logic  lo;
    string tag;
  } item_t;
  item_t sbq[$];

  // reference model state
  int m_S   = 32'h3fff_ffff;
  int m_N   = 1;
  int m_H   = 1;
  bit m_byp = 1'b0;
  bit m_en  = 1'b0;
  bit m_err = 1'b0;

  always #2 clk_in = ~clk_in;
  always @(posedge clk_in) cyc <= cyc + 1;

  sdiv_channel i_sdiv_channel (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .sync_i    (sync_i),
    .ratio_cfg (ratio_cfg),
    .delay_cfg (delay_cfg),
    .out_en    (out_en),
    .clk_out   (clk_out),
    .cfg_err   (cfg_err)
  );

  function automatic int ratio_model(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      3'd5: return 12;
      3'd6: return 16;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // driver: one call per input edge, pushes the expected output of that edge
  task automatic step(input bit oe, input bit sy, input logic [2:0] code,
                      input logic [7:0] d, input string tag);
    int  e;
    bit  dv, bnd;
    item_t it;
    @(negedge clk_in);
    out_en    = oe;
    sync_i    = sy;
    ratio_cfg = code;
    delay_cfg = d;
    e   = cyc + 1;
    dv  = (e >= m_S) && (((e - m_S) % m_N) < m_H);
    bnd = (e >= m_S) && (((e - m_S) % m_N) == 0);
    if (!oe)      m_en = 1'b0;
    else if (bnd) m_en = 1'b1;
    if (sy) begin
      m_N   = ratio_model(code);
      m_H   = (m_N == 1) ? 1 : m_N / 2;
      m_byp = (m_N == 1);
      m_S   = e + int'(d) + 2;
      m_err = (code == 3'b111);
    end
    it.cyc = e;
    it.hi  = m_en & dv;
    it.lo  = m_byp ? 1'b0 : (m_en & dv);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic run(input int n, input bit oe, input logic [2:0] code,
                     input logic [7:0] d, input string tag);
    for (int i = 0; i < n; i++) step(oe, 1'b0, code, d, tag);
  endtask

  task automatic sync_to(input logic [2:0] code, input logic [7:0] d, input string tag);
    step(1'b1, 1'b1, code, d, tag);
    @(posedge clk_in);
    #1;
    check(cfg_err === m_err, {tag, " R2 cfg_err"}, cfg_err, m_err);
  endtask

  // monitor: samples in the high and the low half of each cycle
  initial begin
    forever begin
      @(posedge clk_in);
      #1;
      while (sbq.size() > 0 && sbq[0].cyc < cyc) void'(sbq.pop_front());
      if (sbq.size() > 0 && sbq[0].cyc == cyc) begin
        check(clk_out === sbq[0].hi, {sbq[0].tag, " high half"}, clk_out, sbq[0].hi);
        #2;
        check(clk_out === sbq[0].lo, {sbq[0].tag, " low half"}, clk_out, sbq[0].lo);
        void'(sbq.pop_front());
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sync_i = 1'b0; ratio_cfg = 3'd0; delay_cfg = 8'd0; out_en = 1'b1;
    repeat (4) @(negedge clk_in);
    rst_n = 1'b1;
    #1;
    check(clk_out === 1'b0, "R9 reset clk_out", clk_out, 1'b0);
    check(cfg_err === 1'b0, "R9 reset cfg_err", cfg_err, 1'b0);
    run(8, 1'b1, 3'd2, 8'd0, "R9 idle before sync");

    sync_to(3'd2, 8'd0, "R4 div4 d0");
    run(20, 1'b1, 3'd2, 8'd0, "R1 div4");

    sync_to(3'd3, 8'd3, "R4 div6 d3");
    run(30, 1'b1, 3'd3, 8'd3, "R1 div6");

    sync_to(3'd5, 8'd5, "R1 div12 d5");
    run(40, 1'b1, 3'd5, 8'd5, "R1 div12");

    run(30, 1'b1, 3'd1, 8'd9, "R6 cfg change without sync");

    sync_to(3'd6, 8'd255, "R5 div16 d255");
    run(300, 1'b1, 3'd6, 8'd255, "R5 div16 long delay");

    run(11, 1'b0, 3'd6, 8'd255, "R7 disabled div16");
    run(40, 1'b1, 3'd6, 8'd255, "R8 reenable div16");

    run(7, 1'b1, 3'd6, 8'd255, "R10 before resync");
    sync_to(3'd4, 8'd7, "R10 resync div8 d7");
    run(30, 1'b1, 3'd4, 8'd7, "R10 div8 after resync");

    sync_to(3'd0, 8'd2, "R3 bypass d2");
    run(12, 1'b1, 3'd0, 8'd2, "R3 bypass");
    run(4, 1'b0, 3'd0, 8'd2, "R7 disabled bypass");
    run(8, 1'b1, 3'd0, 8'd2, "R8 reenable bypass");

    sync_to(3'd7, 8'd1, "R2 reserved code");
    run(10, 1'b1, 3'd7, 8'd1, "R2 reserved acts as div1");
    sync_to(3'd1, 8'd0, "R2 valid code clears");
    run(12, 1'b1, 3'd1, 8'd0, "R1 div2");

    repeat (3) @(negedge clk_in);
    finish_run();
  end

endmodule